// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block is the digital sequencer of a multiphase synchronous buck controller. When it is enabled, it first works out how many power stages are fitted, from two to four. For a fixed probe interval it drives the third and fourth PWM pins in a weak probe mode and holds the first two low. On the last clock of that interval it reads two comparator results that say whether pin 3 or pin 4 is tied to ground. The phase count it derives is latched and reported, and the ready flag is raised.

After the probe interval, a free-running internal oscillator of `OSC_PERIOD` clocks is divided into equal slots, one for each active phase. At the start of each slot the matching phase latch is set, in the order phase 1, 2, 3, 4, skipping phases that are not fitted. An external modulator ends each pulse with a per-phase reset trigger. It may also set a phase early with a per-phase set trigger. Each phase latch runs on its own, so pulses may overlap and a phase may stay on for nearly the whole period.

Dropping `enable` or asserting `rstN` clears every output at once. Detection runs again on the next enable.

Top module: `mpwm_sequencer`

## Requirements
- R1: While `rstN` is low, and from the first clock edge that samples `enable` low, `pwmOut` is 0000 and `probeEn` and `ready` are low.
- R2: After the edge that first samples `enable` high, `probeEn` is high for exactly DET_PERIODS×OSC_PERIOD clocks (48 by default). During that interval `ready` is low and `pwmOut` stays 0000 whatever the set triggers do.
- R3: `phaseCount` is a binary count. It is 4 when neither probe input is high, 3 when only `pin4Low` is high, and 2 whenever `pin3Low` is high, whatever `pin4Low` is.
- R4: The probe inputs are sampled only on the last clock of the probe interval. Changes to them while `ready` is high leave `phaseCount` unchanged.
- R5: A phase beyond `phaseCount` (bit 2 and up for a count of 2, bit 3 for a count of 3) stays low even when its set trigger is driven.
- R6: With a count of N, slot k (k = 0..N-1) begins when the oscillator counter equals k×OSC_PERIOD/N. The counter is 0 on the first clock after the probe interval. `pwmOut[k]` rises one clock after its slot begins, so the active phases rise in ascending bit order at even spacing.
- R7: `rstTrig[k]` clears `pwmOut[k]` on the next clock. It wins over `setTrig[k]` and over a slot start in the same cycle, and the other phases are unaffected.
- R8: `setTrig[k]` on an active phase sets `pwmOut[k]` on the next clock, at any point of the period. The output then stays high across period boundaries until a reset trigger arrives.
- R9: Several phase outputs may be high at the same time. With four phases and no reset triggers, `pwmOut` reaches 1111.
- R10: Lowering `enable` while running clears `pwmOut` and `ready` on the next clock. Raising it again restarts the probe interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; a rising level starts phase detection |
| pin3Low | input | 1 | Comparator result: phase-3 pin reads grounded |
| pin4Low | input | 1 | Comparator result: phase-4 pin reads grounded |
| setTrig | input | 4 | Per-phase set trigger from the modulator |
| rstTrig | input | 4 | Per-phase reset trigger from the modulator |
| pwmOut | output | 4 | Per-phase PWM logic outputs |
| probeEn | output | 1 | Probe drive on pins 3 and 4 during detection |
| phaseCount | output | 3 | Detected number of active phases (2, 3 or 4) |
| ready | output | 1 | Detection finished, phases running |

## Verification
The bound checker enforces these rules on every clock: outputs stay quiet when disabled or probing, the count matches the probe inputs seen on the last probe clock, the count is held while running, unfitted phases stay low, and a reset trigger always clears its phase on the next edge. The bench scenarios show the timing of the sequence itself. They check the exact length of the probe interval, the slot positions and rise order for each phase count, early set triggers, and output held high across a period. They also check the overlapped 1111 state and a fresh detection after enable is toggled.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int PHASES = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PROBE = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  // strobes from control to the phase latches
  typedef struct packed {
    logic              run;
    logic [PHASES-1:0] phaseOn;
    logic [PHASES-1:0] slotStrobe;
  } seq_ctl_t;

  // pin 3 grounded forces two phases; pin 4 alone gives three
  function automatic logic [2:0] decodeCount(input logic p3Low, input logic p4Low);
    if (p3Low)      return 3'd2;
    else if (p4Low) return 3'd3;
    else            return 3'd4;
  endfunction

  function automatic logic [PHASES-1:0] phaseMask(input logic [2:0] cnt);
    case (cnt)
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int OSC_PERIOD  = 24,
  parameter int DET_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       pin3Low,
  input  logic       pin4Low,
  output seq_ctl_t   ctl,
  output logic       probeEn,
  output logic       ready,
  output logic [2:0] phaseCount
);
  localparam int DET_TOTAL = OSC_PERIOD * DET_PERIODS;
  localparam int CW = $clog2(DET_TOTAL);
  localparam logic [CW-1:0] DET_LAST = CW'(DET_TOTAL - 1);
  localparam logic [CW-1:0] OSC_LAST = CW'(OSC_PERIOD - 1);
  localparam logic [CW-1:0] SP2 = CW'(OSC_PERIOD / 2);
  localparam logic [CW-1:0] SP3 = CW'(OSC_PERIOD / 3);
  localparam logic [CW-1:0] SP4 = CW'(OSC_PERIOD / 4);

  seq_state_t        state;
  logic [CW-1:0]     tick;
  logic [CW-1:0]     spacing;
  logic [PHASES-1:0] onMask;
  logic [PHASES-1:0] strobeVec;
  logic              runNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      tick       <= '0;
      phaseCount <= 3'd4;
    end else begin
      case (state)
        SEQ_IDLE: begin
          tick <= '0;
          if (enable) state <= SEQ_PROBE;
        end
        SEQ_PROBE: begin
          if (!enable) begin
            state <= SEQ_IDLE;
            tick  <= '0;
          end else if (tick == DET_LAST) begin
            phaseCount <= decodeCount(pin3Low, pin4Low);
            state      <= SEQ_RUN;
            tick       <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        SEQ_RUN: begin
          if (!enable) begin
            state <= SEQ_IDLE;
            tick  <= '0;
          end else if (tick == OSC_LAST) begin
            tick <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: begin
          state <= SEQ_IDLE;
          tick  <= '0;
        end
      endcase
    end
  end

  always_comb begin
    case (phaseCount)
      3'd2:    spacing = SP2;
      3'd3:    spacing = SP3;
      default: spacing = SP4;
    endcase
  end

  assign runNow  = (state == SEQ_RUN) && enable;
  assign onMask  = phaseMask(phaseCount);
  assign probeEn = (state == SEQ_PROBE);
  assign ready   = (state == SEQ_RUN);

  for (genvar k = 0; k < PHASES; k++) begin : g_slot
    assign strobeVec[k] = runNow && onMask[k] && (tick == CW'(k) * spacing);
  end

  assign ctl = '{run: runNow, phaseOn: onMask, slotStrobe: strobeVec};
endmodule

// File: rtl/mpwm_datapath.sv
module mpwm_datapath
  import mpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [PHASES-1:0] setTrig,
  input  logic [PHASES-1:0] rstTrig,
  output logic [PHASES-1:0] pwmOut
);
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              pwmOut[p] <= 1'b0;
      else if (!ctl.run || !ctl.phaseOn[p])   pwmOut[p] <= 1'b0;
      else if (rstTrig[p])                    pwmOut[p] <= 1'b0;
      else if (ctl.slotStrobe[p] || setTrig[p]) pwmOut[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/mpwm_sequencer.sv
module mpwm_sequencer
  import mpwm_pkg::*;
#(
  parameter int OSC_PERIOD  = 24,
  parameter int DET_PERIODS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       pin3Low,
  input  logic       pin4Low,
  input  logic [3:0] setTrig,
  input  logic [3:0] rstTrig,
  output logic [3:0] pwmOut,
  output logic       probeEn,
  output logic [2:0] phaseCount,
  output logic       ready
);
  seq_ctl_t ctl;

  mpwm_ctrl #(.OSC_PERIOD(OSC_PERIOD), .DET_PERIODS(DET_PERIODS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .pin3Low(pin3Low), .pin4Low(pin4Low),
    .ctl(ctl), .probeEn(probeEn), .ready(ready), .phaseCount(phaseCount)
  );

  mpwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .setTrig(setTrig), .rstTrig(rstTrig),
    .pwmOut(pwmOut)
  );
endmodule

// File: rtl/mpwm_seq_chk.sv
module mpwm_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       pin3Low,
  input logic       pin4Low,
  input logic [3:0] rstTrig,
  input logic [3:0] pwmOut,
  input logic       probeEn,
  input logic [2:0] phaseCount,
  input logic       ready
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == 4'b0000 && !ready && !probeEn));

  // R2
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeEn |-> (pwmOut == 4'b0000 && !ready));

  // R3
  count_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> phaseCount == ($past(pin3Low) ? 3'd2 : ($past(pin4Low) ? 3'd3 : 3'd4)));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready)) |-> $stable(phaseCount));

  // R5
  phase4_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && phaseCount != 3'd4) |-> !pwmOut[3]);

  // R5
  phase3_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && phaseCount == 3'd2) |-> !pwmOut[2]);

  // R7
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstTrig != 4'b0000) |=> ((pwmOut & $past(rstTrig)) == 4'b0000));
endmodule

bind mpwm_sequencer mpwm_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .pin3Low(pin3Low), .pin4Low(pin4Low),
  .rstTrig(rstTrig), .pwmOut(pwmOut), .probeEn(probeEn), .phaseCount(phaseCount),
  .ready(ready)
);

// File: tb/mpwm_sequencer_test.sv
module mpwm_sequencer_test;
  localparam int OSC = 24;
  localparam int DETP = 2;
  localparam int WIN = OSC * DETP;
  // {pin3Low, pin4Low, expected count}
  localparam logic [4:0] VEC [4] = '{5'b00_100, 5'b01_011, 5'b11_010, 5'b10_010};

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       pin3Low, pin4Low;
  logic [3:0] setTrig, rstTrig;
  logic [3:0] pwmOut;
  logic       probeEn;
  logic [2:0] phaseCount;
  logic       ready;

  int total = 0;
  int bad = 0;
  int pos = 0;

  always #4 clk = ~clk;

  mpwm_sequencer #(.OSC_PERIOD(OSC), .DET_PERIODS(DETP)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .pin3Low(pin3Low), .pin4Low(pin4Low),
    .setTrig(setTrig), .rstTrig(rstTrig), .pwmOut(pwmOut), .probeEn(probeEn),
    .phaseCount(phaseCount), .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at pos %0d", req, act, exp, pos);
    end
  endtask

  // advance to the falling edge that follows rising edge j (counted from enable)
  task automatic adv(input int j);
    while (pos < j) begin
      @(negedge clk);
      pos++;
    end
  endtask

  task automatic startRun(input logic g3, input logic g4);
    @(negedge clk);
    pin3Low = g3;
    pin4Low = g4;
    enable  = 1'b1;
    pos     = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; pin3Low = 1'b0; pin4Low = 1'b0;
    setTrig = 4'h0; rstTrig = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwmOut), 0);
    chk("R1 ready/probe in reset", int'({ready, probeEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle while disabled", int'({pwmOut, ready, probeEn}), 0);

    for (int v = 0; v < 4; v++) begin
      automatic int expCnt = int'(VEC[v][2:0]);
      automatic int sp = OSC / expCnt;
      automatic int mask = (1 << expCnt) - 1;
      startRun(VEC[v][4], VEC[v][3]);
      setTrig = 4'hF;
      adv(0);
      chk("R2 probe on at start", int'({probeEn, ready}), 2);
      chk("R2 pwm off at start", int'(pwmOut), 0);
      adv(WIN - 1);
      chk("R2 probe on at window end", int'({probeEn, ready}), 2);
      chk("R2 set ignored while probing", int'(pwmOut), 0);
      setTrig = 4'h0;
      adv(WIN);
      chk("R2 probe off after window", int'({probeEn, ready}), 1);
      chk("R3 phase count", int'(phaseCount), expCnt);
      pin3Low = ~pin3Low;
      pin4Low = ~pin4Low;
      for (int k = 0; k < expCnt; k++) begin
        adv(WIN + k * sp);
        chk("R6 phase low before slot", int'(pwmOut[k]), 0);
        adv(WIN + 1 + k * sp);
        chk("R6 phase rises at slot", int'(pwmOut[k]), 1);
      end
      adv(WIN + 1 + OSC);
      setTrig = 4'hF;
      adv(WIN + 2 + OSC);
      chk("R5 R9 active phases only", int'(pwmOut), mask);
      chk("R4 count held", int'(phaseCount), expCnt);
      setTrig = 4'h0;
      enable  = 1'b0;
      adv(WIN + 3 + OSC);
      chk("R10 disable clears", int'({pwmOut, ready}), 0);
    end

    // four phases, overlapped, then trigger corners
    startRun(1'b0, 1'b0);
    adv(WIN + 2 + OSC);
    chk("R9 all phases overlap", int'(pwmOut), 15);
    rstTrig = 4'b0010;
    setTrig = 4'b0010;
    adv(pos + 1);
    chk("R7 reset beats set", int'(pwmOut), 13);
    setTrig = 4'b0000;
    rstTrig = 4'b0100;
    adv(pos + 1);
    rstTrig = 4'b0000;
    chk("R7 reset clears phase", int'(pwmOut[2]), 0);
    setTrig = 4'b0100;
    adv(pos + 1);
    setTrig = 4'b0000;
    chk("R8 early set", int'(pwmOut[2]), 1);
    adv(pos + OSC + 5);
    chk("R8 held across period", int'(pwmOut[2]), 1);

    // drop enable during probing, then re-enable
    enable = 1'b0;
    adv(pos + 1);
    startRun(1'b0, 1'b1);
    adv(5);
    chk("R10 restart probes", int'(probeEn), 1);
    enable = 1'b0;
    adv(6);
    chk("R10 probe abort", int'({probeEn, ready}), 0);

    // async reset in run
    startRun(1'b0, 1'b0);
    adv(WIN + 2 + OSC);
    #1 rstN = 1'b0;
    #1 chk("R1 async reset clears", int'({pwmOut, ready}), 0);
    rstN = 1'b1;
    enable = 1'b0;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule